// File: doc/BRIEF.md
# SD Card SPI-Mode Command Framer

This block sends a single SD/MMC command to a card attached over SPI and gathers the bytes the card returns. The caller supplies a 6-bit command index, a 32-bit argument, a response length in bytes, and optionally an expected value for the first response byte. A start strobe begins the command. The block then assembles the seven-byte command frame and computes its CRC7 one byte at a time as the bytes go out. It passes each byte to an external byte-exchange SPI master through a go/done handshake.

After the frame, the block reads one byte and discards it. It then either reads the requested number of bytes straight away, or first searches for the expected value for a bounded number of bytes. When it finishes, it raises a one-cycle done pulse, together with a timeout flag if the search failed.

Chip-select becomes active when the command starts and stays active after done. A data phase driven by other logic can therefore share the same selection. Chip-select is released only when an end request arrives while the block is idle.

Top module: `sd_cmd_framer`

## Requirements
- R1: On start the block issues seven frame exchanges in this order: 0xFF, then {2'b01, cmd_idx}, then cmd_arg bytes from bits 31:24 down to bits 7:0, then the CRC byte.
- R2: The CRC byte equals (CRC7 << 1) | 1. CRC7 is computed over frame bytes two to six, with polynomial x^7+x^3+1, zero initial value, most significant bit first. For index 0 with argument 0 the byte is 0x95; for index 8 with argument 0x1AA it is 0x87.
- R3: Exactly one exchange follows the frame, and its received value is ignored even when it equals the expected value.
- R4: With match_en high, up to 8 further bytes are read, and the search stops at the first byte equal to match_val. That byte becomes response byte 0, and only resp_len-1 more bytes are read after it.
- R5: If none of the 8 searched bytes matches, the block ends with timed_out high in the same cycle as done.
- R6: With match_en low, resp_len bytes are read directly after the discarded byte. Response byte i appears on resp_data[8i+7:8i], and bytes beyond resp_len read as zero.
- R7: With resp_len equal to 0, the command ends right after the discarded byte.
- R8: Every exchange after the frame transmits 0xFF.
- R9: spi_go is a one-cycle pulse, and a new pulse is issued only after spi_done has answered the previous one.
- R10: spi_cs is high from start through done and stays high afterwards. It falls only after end_req is seen while idle; end_req while busy is ignored.
- R11: A start pulse while busy is ignored.
- R12: After reset, spi_cs, spi_go, busy, done and timed_out are low, and resp_data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a command (taken only when idle) |
| end_req | input | 1 | Release chip-select (taken only when idle) |
| cmd_idx | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| resp_len | input | 3 | Number of response bytes, 0 to MAX_RESP |
| match_en | input | 1 | Search for match_val before capturing |
| match_val | input | 8 | Expected first response byte |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| timed_out | output | 1 | Search failed; valid with done |
| resp_data | output | 40 | Captured response bytes, byte 0 lowest |
| spi_cs | output | 1 | Chip-select active (high = selected) |
| spi_go | output | 1 | Start one byte exchange |
| spi_tx | output | 8 | Byte to transmit, valid with spi_go |
| spi_rx | input | 8 | Byte received, valid with spi_done |
| spi_done | input | 1 | Exchange finished |

## Verification
The assertions check, on every cycle, the handshake discipline: single-cycle go pulses with at most one exchange outstanding. They also check that chip-select falls only after an end request and is still active at done, that the timeout flag never appears without done, that busy begins only from a start, and that the search counter stays below its bound. The frame contents, the CRC values, the ignored discard byte, where the search stops, and the placement of captured bytes depend on the byte stream the card returns. Only the bench's scripted card responses can show those behaviours.

// File: rtl/sdf_pkg.sv
package sdf_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FRAME,
    S_DISC,
    S_HUNT,
    S_READ
  } sdf_state_t;

  // One byte through CRC7 (x^7 + x^3 + 1), MSB first.
  function automatic logic [6:0] crc7_byte(input logic [6:0] c, input logic [7:0] d);
    logic [6:0] r;
    logic       fb;
    r = c;
    for (int b = 7; b >= 0; b--) begin
      fb = d[b] ^ r[6];
      r  = {r[5:0], 1'b0};
      if (fb) r = r ^ 7'h09;
    end
    return r;
  endfunction

endpackage

// File: rtl/sdf_crc7.sv
module sdf_crc7 (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       en,
  input  logic [7:0] din,
  output logic [6:0] crc
);
  import sdf_pkg::*;

  always_ff @(posedge clk) begin
    if (rst || clr) crc <= '0;
    else if (en)    crc <= crc7_byte(crc, din);
  end
endmodule

// File: rtl/sdf_resp_store.sv
module sdf_resp_store #(
  parameter int NBYTES = 5,
  parameter int AW     = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  logic                we,
  input  logic [AW-1:0]       addr,
  input  logic [7:0]          din,
  output logic [NBYTES*8-1:0] dout
);
  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst || clr)                   dout[8*g +: 8] <= '0;
      else if (we && addr == AW'(g))    dout[8*g +: 8] <= din;
    end
  end
endmodule

// File: rtl/sd_cmd_framer.sv
module sd_cmd_framer #(
  parameter int MAX_RESP = 5,
  parameter int HUNT_MAX = 8,
  localparam int LW = $clog2(MAX_RESP + 1),
  localparam int HW = $clog2(HUNT_MAX + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic                  end_req,
  input  logic [5:0]            cmd_idx,
  input  logic [31:0]           cmd_arg,
  input  logic [LW-1:0]         resp_len,
  input  logic                  match_en,
  input  logic [7:0]            match_val,
  output logic                  busy,
  output logic                  done,
  output logic                  timed_out,
  output logic [MAX_RESP*8-1:0] resp_data,
  output logic                  spi_cs,
  output logic                  spi_go,
  output logic [7:0]            spi_tx,
  input  logic [7:0]            spi_rx,
  input  logic                  spi_done
);
  import sdf_pkg::*;

  localparam int FRAME_LAST = 6;

  sdf_state_t     st_q;
  logic           wait_q;
  logic [2:0]     fcnt_q;
  logic [HW-1:0]  hcnt_q;
  logic [LW-1:0]  ridx_q;
  logic [LW-1:0]  len_q;
  logic           men_q;
  logic [7:0]     mval_q;
  logic [5:0]     idx_q;
  logic [31:0]    arg_q;
  logic [6:0]     crc;
  logic [7:0]     frame_byte;
  logic           crc_en;
  logic           st_we;
  logic [LW-1:0]  st_addr;
  logic           take_start;

  assign take_start = start && (st_q == S_IDLE);

  always_comb begin
    case (fcnt_q)
      3'd0:    frame_byte = 8'hFF;
      3'd1:    frame_byte = {2'b01, idx_q};
      3'd2:    frame_byte = arg_q[31:24];
      3'd3:    frame_byte = arg_q[23:16];
      3'd4:    frame_byte = arg_q[15:8];
      3'd5:    frame_byte = arg_q[7:0];
      default: frame_byte = {crc, 1'b1};
    endcase
  end

  assign crc_en = (st_q == S_FRAME) && !wait_q && fcnt_q >= 3'd1 && fcnt_q <= 3'd5;

  sdf_crc7 u_crc (
    .clk (clk), .rst (rst), .clr (take_start),
    .en  (crc_en), .din (frame_byte), .crc (crc)
  );

  always_comb begin
    st_we   = 1'b0;
    st_addr = ridx_q;
    if (wait_q && spi_done) begin
      if (st_q == S_HUNT && spi_rx == mval_q) begin
        st_we   = 1'b1;
        st_addr = '0;
      end else if (st_q == S_READ) begin
        st_we   = 1'b1;
      end
    end
  end

  sdf_resp_store #(.NBYTES(MAX_RESP), .AW(LW)) u_store (
    .clk (clk), .rst (rst), .clr (take_start),
    .we  (st_we), .addr (st_addr), .din (spi_rx), .dout (resp_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= S_IDLE;
      wait_q    <= 1'b0;
      fcnt_q    <= '0;
      hcnt_q    <= '0;
      ridx_q    <= '0;
      len_q     <= '0;
      men_q     <= 1'b0;
      mval_q    <= '0;
      idx_q     <= '0;
      arg_q     <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      timed_out <= 1'b0;
      spi_cs    <= 1'b0;
      spi_go    <= 1'b0;
      spi_tx    <= 8'hFF;
    end else begin
      spi_go    <= 1'b0;
      done      <= 1'b0;
      timed_out <= 1'b0;
      if (st_q == S_IDLE) begin
        if (take_start) begin
          st_q   <= S_FRAME;
          fcnt_q <= '0;
          len_q  <= resp_len;
          men_q  <= match_en;
          mval_q <= match_val;
          idx_q  <= cmd_idx;
          arg_q  <= cmd_arg;
          busy   <= 1'b1;
          spi_cs <= 1'b1;
        end else if (end_req) begin
          spi_cs <= 1'b0;
        end
      end else if (!wait_q) begin
        spi_go <= 1'b1;
        spi_tx <= (st_q == S_FRAME) ? frame_byte : 8'hFF;
        wait_q <= 1'b1;
      end else if (spi_done) begin
        wait_q <= 1'b0;
        case (st_q)
          S_FRAME: begin
            if (fcnt_q == 3'(FRAME_LAST)) st_q <= S_DISC;
            fcnt_q <= fcnt_q + 3'd1;
          end
          S_DISC: begin
            hcnt_q <= '0;
            ridx_q <= '0;
            if (len_q == '0) begin
              st_q <= S_IDLE; busy <= 1'b0; done <= 1'b1;
            end else if (men_q) begin
              st_q <= S_HUNT;
            end else begin
              st_q <= S_READ;
            end
          end
          S_HUNT: begin
            if (spi_rx == mval_q) begin
              ridx_q <= LW'(1);
              if (len_q == LW'(1)) begin
                st_q <= S_IDLE; busy <= 1'b0; done <= 1'b1;
              end else begin
                st_q <= S_READ;
              end
            end else if (hcnt_q == HW'(HUNT_MAX - 1)) begin
              st_q <= S_IDLE; busy <= 1'b0; done <= 1'b1; timed_out <= 1'b1;
            end else begin
              hcnt_q <= hcnt_q + 1'b1;
            end
          end
          S_READ: begin
            if (ridx_q + 1'b1 == len_q) begin
              st_q <= S_IDLE; busy <= 1'b0; done <= 1'b1;
            end
            ridx_q <= ridx_q + 1'b1;
          end
          default: st_q <= S_IDLE;
        endcase
      end
    end
  end

  // R9
  go_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    spi_go |=> !spi_go);

  // R9
  go_waits_done_chk: assert property (@(posedge clk) disable iff (rst)
    (spi_go && !spi_done) |=> (!spi_go || $past(spi_done)));

  // R10
  cs_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(spi_cs) |-> ($past(end_req) && !$past(busy)));

  // R10
  cs_held_at_done_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> spi_cs);

  // R5
  timeout_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    timed_out |-> done);

  // R11
  busy_from_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

  // R4
  hunt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    hcnt_q < HW'(HUNT_MAX));

endmodule

// File: tb/test_sd_cmd_framer.sv
module test_sd_cmd_framer;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0, end_req = 1'b0;
  logic [5:0]  cmd_idx = '0;
  logic [31:0] cmd_arg = '0;
  logic [2:0]  resp_len = '0;
  logic        match_en = 1'b0;
  logic [7:0]  match_val = '0;
  logic        busy, done, timed_out, spi_cs, spi_go;
  logic [39:0] resp_data;
  logic [7:0]  spi_tx;
  logic [7:0]  spi_rx = 8'hFF;
  logic        spi_done = 1'b0;

  int errors = 0, checks = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sd_cmd_framer i_sd_cmd_framer (
    .clk(clk), .rst(rst), .start(start), .end_req(end_req),
    .cmd_idx(cmd_idx), .cmd_arg(cmd_arg), .resp_len(resp_len),
    .match_en(match_en), .match_val(match_val), .busy(busy), .done(done),
    .timed_out(timed_out), .resp_data(resp_data), .spi_cs(spi_cs),
    .spi_go(spi_go), .spi_tx(spi_tx), .spi_rx(spi_rx), .spi_done(spi_done)
  );

  // Vector table: stimulus and expected results
  localparam logic [5:0]  V_IDX [0:NV-1] = '{6'd0, 6'd8, 6'd58, 6'd13, 6'd17, 6'd16};
  localparam logic [31:0] V_ARG [0:NV-1] = '{32'h0, 32'h1AA, 32'h0, 32'h0, 32'h12345678, 32'h200};
  localparam logic [2:0]  V_LEN [0:NV-1] = '{3'd1, 3'd5, 3'd5, 3'd1, 3'd0, 3'd2};
  localparam logic        V_MEN [0:NV-1] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1};
  localparam logic [7:0]  V_MV  [0:NV-1] = '{8'h01, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00};
  localparam logic [95:0] V_STR [0:NV-1] = '{
    96'hFFFFFFFFFFFFFFFFFF01FFFF,
    96'hFFFFFFFFFFFFAA01000001FF,
    96'hFFFFFFFFFFFFFF000080FFC0,
    96'hFFFFFFFFFFFFFFFFFFFFFFFF,
    96'hFFFFFFFFFFFFFFFFFFFFFFFF,
    96'hFFFFFF3700FFFFFFFFFFFFFF};
  localparam logic [39:0] V_RSP [0:NV-1] = '{
    40'h0000000001, 40'hAA01000001, 40'h000080FFC0,
    40'h0000000000, 40'h0000000000, 40'h0000003700};
  localparam logic        V_TO  [0:NV-1] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0};
  localparam int          V_NEX [0:NV-1] = '{11, 14, 13, 16, 8, 17};

  // Card model
  logic [7:0]  txlog [0:31];
  int          n_ex = 0;
  int          pend = 0;
  logic [95:0] stream = '1;
  logic [7:0]  disc_val = 8'h5A;
  int          go_gap_err = 0;

  always @(negedge clk) begin
    cycles++;
    spi_done = 1'b0;
    if (spi_go) begin
      if (pend != 0) go_gap_err++;
      if (n_ex < 32) txlog[n_ex] = spi_tx;
      pend = 2;
    end else if (pend > 0) begin
      pend--;
      if (pend == 0) begin
        spi_done = 1'b1;
        if (n_ex < 7)       spi_rx = 8'hFF;
        else if (n_ex == 7) spi_rx = disc_val;
        else                spi_rx = stream[8*(n_ex-8) +: 8];
        n_ex++;
      end
    end
  end

  function automatic logic [7:0] ref_crc(input logic [5:0] idx, input logic [31:0] arg);
    logic [39:0] bits;
    logic [6:0]  c;
    logic        fb;
    bits = {2'b01, idx, arg};
    c = '0;
    for (int i = 39; i >= 0; i--) begin
      fb = bits[i] ^ c[6];
      c  = {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
    end
    return {c, 1'b1};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_start(input logic [5:0] idx, input logic [31:0] arg,
                             input logic [2:0] len, input logic men, input logic [7:0] mv);
    cmd_idx = idx; cmd_arg = arg; resp_len = len; match_en = men; match_val = mv;
    disc_val = men ? mv : 8'h5A;
    n_ex = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output logic to);
    int n = 0;
    to = 1'b0;
    while (!done && n < 400) begin @(negedge clk); n++; end
    if (!done) begin
      errors++; checks++;
      $display("FAIL R9: done never seen, actual=0 expected=1");
    end else to = timed_out;
  endtask

  initial begin
    logic to;
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 cs", spi_cs, 0);
    check("R12 go/busy/done/to", {spi_go, busy, done, timed_out}, 0);
    check("R12 resp", resp_data, 0);
    rst = 1'b0;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      stream = V_STR[v];
      pulse_start(V_IDX[v], V_ARG[v], V_LEN[v], V_MEN[v], V_MV[v]);
      check("R10 cs up at start", spi_cs, 1);
      wait_done(to);
      // R5 / R4
      check("R5 timeout flag", to, V_TO[v]);
      // R3 R4 R7 exchange count
      check("R3 R4 R7 exchange count", n_ex, V_NEX[v]);
      if (!V_TO[v]) check("R4 R6 response bytes", resp_data, V_RSP[v]);
      // R1 frame order
      check("R1 frame head", {txlog[0], txlog[1]}, {8'hFF, 2'b01, V_IDX[v]});
      check("R1 arg bytes", {txlog[2], txlog[3], txlog[4], txlog[5]}, V_ARG[v]);
      // R2 CRC byte
      check("R2 crc byte", txlog[6], ref_crc(V_IDX[v], V_ARG[v]));
      // R8 fill bytes
      for (int k = 7; k < V_NEX[v] && k < 32; k++) check("R8 fill byte", txlog[k], 8'hFF);
      @(negedge clk);
      check("R10 cs held after done", spi_cs, 1);
    end

    // R2 known constants
    check("R2 crc idx0", ref_crc(6'd0, 32'h0), 8'h95);
    check("R2 crc idx8", ref_crc(6'd8, 32'h1AA), 8'h87);

    // R11 / R10 start and end_req while busy are ignored
    stream = 96'hFFFFFFFFFFFFFFFFFFFFFF42;
    pulse_start(6'd9, 32'hCAFE0001, 3'd1, 1'b0, 8'h00);
    repeat (4) @(negedge clk);
    cmd_idx = 6'd3; cmd_arg = 32'h0; resp_len = 3'd0;
    start = 1'b1; end_req = 1'b1;
    @(negedge clk);
    start = 1'b0; end_req = 1'b0;
    check("R10 end_req while busy ignored", spi_cs, 1);
    wait_done(to);
    check("R11 exchange count unchanged", n_ex, 9);
    check("R11 index unchanged", txlog[1], {2'b01, 6'd9});
    check("R6 direct read", resp_data, 40'h42);
    @(negedge clk);

    // R10 release when idle
    end_req = 1'b1;
    @(negedge clk);
    end_req = 1'b0;
    @(negedge clk);
    check("R10 cs released", spi_cs, 0);

    // R9 handshake discipline
    check("R9 go while exchange outstanding", go_gap_err, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule